// File: doc/BRIEF.md
# Stack and Register-Pair Transfer Sequencer

This block moves 16-bit register pairs between a processor's register file and byte-wide memory. It handles one byte per cycle. It runs four multi-cycle operations:

- **Push a pair:** write a pair onto the stack.
- **Pop a pair:** read a pair off the stack.
- **Swap with the stack top:** exchange the HL pair with the two bytes on top of the stack.
- **Direct load:** load HL from any 16-bit address.

The block owns the 16-bit stack pointer. It drives a simple synchronous memory port whose read data arrives one cycle after the address.

**Issuing a command.** The surrounding datapath presents the following on a cycle where `busy` is low:

- an operation code;
- a pair code;
- an address, used only by the direct load;
- a 16-bit operand, which is the pair to push or the current HL for a swap.

**Completion.** The block raises `done` for one cycle when the sequence completes. For pop, swap and direct load, the pair that was read is then on `res_pair`. It stays there until the next read-type operation. A pair code of 3 means accumulator plus flags, and the flags byte is treated as opaque data.

Top module: `pairxfer_seq`

## Requirements
- R1: After reset `busy`, `done` and `mem_we` are 0, `sp` equals the SP_RESET parameter (default 0x0000) and `res_pair` is 0x0000.
- R2: Push (op code 0) performs two writes in consecutive cycles. First it writes `cmd_data[15:8]` to address sp-1, then `cmd_data[7:0]` to address sp-2. After that `sp` is 2 lower.
- R3: Pop (op code 1) reads the byte at sp into the low half and the byte at sp+1 into the high half of `res_pair`. `sp` ends 2 higher, and `res_sel` carries the command's pair code.
- R4: Pair codes are 0 = BC, 1 = DE, 2 = HL, 3 = accumulator/flags. For code 3 the accumulator is the high byte (`cmd_data[15:8]`, pushed to the higher address) and the flags byte is the low byte.
- R5: Swap (op code 2) returns {mem[sp+1], mem[sp]} on `res_pair` and leaves mem[sp] = `cmd_data[7:0]` and mem[sp+1] = `cmd_data[15:8]`. `sp` is unchanged and `res_sel` is 2.
- R6: Direct load (op code 3) returns {mem[a+1], mem[a]} for a = `cmd_addr`. It writes no memory, leaves `sp` unchanged and sets `res_sel` to 2.
- R7: Every stack and address step wraps modulo 2^16. A push at sp = 0x0000 writes 0xFFFF then 0xFFFE, and a direct load at 0xFFFF takes its high byte from 0x0000.
- R8: A command offered while `busy` is high is ignored. It causes no memory write, no stack-pointer change and no extra `done`.
- R9: `res_pair` is not changed by a push and holds its value until the next pop, swap or direct load completes.
- R10: `done` is a one-cycle pulse, and `busy` is low in that cycle. `done` comes N clock edges after the accepting edge, with N = 2 for push, 3 for pop and direct load, and 4 for swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered; taken when `busy` is low |
| cmd_op | input | 2 | 0 push, 1 pop, 2 swap HL with stack top, 3 direct load HL |
| cmd_pair | input | 2 | Pair code for push/pop |
| cmd_addr | input | AW | Address for direct load |
| cmd_data | input | 2*DW | Pair to push, or current HL for swap |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| res_pair | output | 2*DW | Last pair read from memory |
| res_sel | output | 2 | Pair code that `res_pair` belongs to |
| sp | output | AW | Stack pointer |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DW | Memory read byte, one cycle after the address |

## Verification
The bench starts from a stack pointer of zero. Its first pushes must therefore wrap, and a design that stepped to 0x10000 or went wrong on the borrow would write bytes to 0x0000 and 0x0001. Pushing the accumulator/flags pair and popping it into another pair exposes a swapped byte order, because the popped value would come back byte-reversed.

The swap is checked both on `res_pair` and in the bench's memory model. A design that captured read data one cycle early would return the previous byte, and one that moved the stack pointer would fail the follow-up pop. A second command is held on the inputs during a push; a design that took it would move `sp` by an extra two and pulse `done` twice.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  localparam int STEP_W = 2;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_XCHG = 2'd2,
    OP_LDHL = 2'd3
  } pxs_op_e;

  localparam logic [1:0] PAIR_BC = 2'd0;
  localparam logic [1:0] PAIR_DE = 2'd1;
  localparam logic [1:0] PAIR_HL = 2'd2;
  localparam logic [1:0] PAIR_AF = 2'd3;

  // index of the final byte step of each operation
  function automatic logic [STEP_W-1:0] final_step(input pxs_op_e op);
    case (op)
      OP_PUSH: final_step = 2'd1;
      OP_XCHG: final_step = 2'd3;
      default: final_step = 2'd2;
    endcase
  endfunction

  // signed address offset from the base for a given step
  function automatic logic signed [2:0] step_offset(input pxs_op_e op,
                                                    input logic [STEP_W-1:0] st);
    case (op)
      OP_PUSH: step_offset = (st == 2'd0) ? -3'sd1 : -3'sd2;
      OP_XCHG: step_offset = {2'b00, st[0]};
      default: step_offset = (st == 2'd0) ? 3'sd0 : 3'sd1;
    endcase
  endfunction

  // net stack-pointer movement on completion
  function automatic logic signed [2:0] sp_delta(input pxs_op_e op);
    case (op)
      OP_PUSH: sp_delta = -3'sd2;
      OP_POP:  sp_delta = 3'sd2;
      default: sp_delta = 3'sd0;
    endcase
  endfunction

endpackage

// File: rtl/pxs_ctrl.sv
module pxs_ctrl
  import pxs_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [1:0]          cmd_pair,
  input  logic [AW-1:0]       cmd_addr,
  input  logic [PW-1:0]       cmd_data,
  input  logic [AW-1:0]       sp,
  output logic                busy,
  output logic                done,
  output logic                accept,
  output logic                finish,
  output pxs_op_e             op_q,
  output logic [1:0]          pair_q,
  output logic [AW-1:0]       base_q,
  output logic [PW-1:0]       data_q,
  output logic [STEP_W-1:0]   step_q
);

  assign accept = cmd_valid && !busy;
  assign finish = busy && (step_q == final_step(op_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      op_q   <= OP_PUSH;
      pair_q <= '0;
      base_q <= '0;
      data_q <= '0;
      step_q <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        step_q <= '0;
        op_q   <= pxs_op_e'(cmd_op);
        pair_q <= cmd_pair;
        data_q <= cmd_data;
        base_q <= (pxs_op_e'(cmd_op) == OP_LDHL) ? cmd_addr : sp;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (busy) begin
        step_q <= step_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pxs_mem_drv.sv
module pxs_mem_drv
  import pxs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              busy,
  input  pxs_op_e           op_q,
  input  logic [STEP_W-1:0] step_q,
  input  logic [AW-1:0]     base_q,
  input  logic [2*DW-1:0]   data_q,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic              cap_lo,
  output logic              cap_hi
);

  logic signed [2:0] off;
  logic              high_byte;
  logic              is_read_op;

  always_comb begin
    off        = step_offset(op_q, step_q);
    mem_addr   = base_q + {{(AW-3){off[2]}}, off};
    is_read_op = (op_q != OP_PUSH);
    mem_we     = busy && ((op_q == OP_PUSH) ||
                          (op_q == OP_XCHG && step_q[1]));
    high_byte  = ((op_q == OP_PUSH) && (step_q == 2'd0)) ||
                 ((op_q == OP_XCHG) && (step_q == 2'd3));
    mem_wdata  = high_byte ? data_q[2*DW-1:DW] : data_q[DW-1:0];
    cap_lo     = busy && is_read_op && (step_q == 2'd1);
    cap_hi     = busy && is_read_op && (step_q == 2'd2);
  end

endmodule

// File: rtl/pxs_collect.sv
module pxs_collect
  import pxs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_lo,
  input  logic            cap_hi,
  input  pxs_op_e         op_q,
  input  logic [1:0]      pair_q,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] res_pair,
  output logic [1:0]      res_sel
);

  logic [DW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q     <= '0;
      res_pair <= '0;
      res_sel  <= '0;
    end else begin
      if (cap_lo) lo_q <= mem_rdata;
      if (cap_hi) begin
        res_pair <= {mem_rdata, lo_q};
        res_sel  <= (op_q == OP_POP) ? pair_q : PAIR_HL;
      end
    end
  end

endmodule

// File: rtl/pxs_sp_reg.sv
module pxs_sp_reg
  import pxs_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [AW-1:0] SP_RESET = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          finish,
  input  pxs_op_e       op_q,
  output logic [AW-1:0] sp
);

  logic signed [2:0] delta;
  assign delta = sp_delta(op_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      sp <= SP_RESET;
    else if (finish) sp <= sp + {{(AW-3){delta[2]}}, delta};
  end

endmodule

// File: rtl/pairxfer_seq.sv
module pairxfer_seq
  import pxs_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [AW-1:0] SP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [1:0]      cmd_pair,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [2*DW-1:0] cmd_data,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] res_pair,
  output logic [1:0]      res_sel,
  output logic [AW-1:0]   sp,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  input  logic [DW-1:0]   mem_rdata
);

  localparam int PW = 2 * DW;

  logic              accept;
  logic              finish;
  logic              cap_lo;
  logic              cap_hi;
  pxs_op_e           op_q;
  logic [1:0]        pair_q;
  logic [AW-1:0]     base_q;
  logic [PW-1:0]     data_q;
  logic [STEP_W-1:0] step_q;

  pxs_ctrl #(.AW(AW), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pair(cmd_pair), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .sp(sp),
    .busy(busy), .done(done), .accept(accept), .finish(finish), .op_q(op_q),
    .pair_q(pair_q), .base_q(base_q), .data_q(data_q), .step_q(step_q)
  );

  pxs_mem_drv #(.AW(AW), .DW(DW)) u_mem (
    .busy(busy), .op_q(op_q), .step_q(step_q), .base_q(base_q),
    .data_q(data_q), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .cap_lo(cap_lo), .cap_hi(cap_hi)
  );

  pxs_collect #(.DW(DW)) u_col (
    .clk(clk), .rst_n(rst_n), .cap_lo(cap_lo), .cap_hi(cap_hi), .op_q(op_q),
    .pair_q(pair_q), .mem_rdata(mem_rdata), .res_pair(res_pair),
    .res_sel(res_sel)
  );

  pxs_sp_reg #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n), .finish(finish), .op_q(op_q), .sp(sp)
  );

endmodule

// File: rtl/pxs_chk.sv
module pxs_chk
  import pxs_pkg::*;
#(
  parameter int AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [AW-1:0]     sp,
  input pxs_op_e           op_q,
  input logic [STEP_W-1:0] step_q
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R8
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q));

  // R1
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R7
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_PUSH && step_q == 2'd0) |-> (mem_addr == AW'(sp - 1'b1)));

  // R5
  xchg_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_XCHG || op_q == OP_LDHL)) |-> (sp == $past(sp)));

  // R2
  sp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sp));

endmodule

bind pairxfer_seq pxs_chk #(.AW(AW)) u_pxs_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_we(mem_we),
  .mem_addr(mem_addr), .sp(sp), .op_q(op_q), .step_q(step_q)
);

// File: tb/test_pairxfer_seq.sv
`timescale 1ns/1ps
module test_pairxfer_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [1:0]  cmd_pair = '0;
  logic [15:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        busy, done, mem_we;
  logic [15:0] res_pair, sp, mem_addr;
  logic [1:0]  res_sel;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] mem [int unsigned];

  always #4 clk = ~clk;

  function automatic logic [7:0] peek(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  always @(posedge clk) begin
    mem_rdata <= peek(mem_addr);
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
  end

  pairxfer_seq i_pairxfer_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pair(cmd_pair), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .busy(busy), .done(done), .res_pair(res_pair), .res_sel(res_sel),
    .sp(sp), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] pr,
                       input logic [15:0] a, input logic [15:0] d,
                       output int n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pair = pr; cmd_addr = a; cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 1;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "mem_we", mem_we, 0);
    chk("R1", "sp", sp, 16'h0000);
    chk("R1", "res_pair", res_pair, 16'h0000);
  endtask

  task automatic t_push_bc();
    int n;
    issue(2'd0, 2'd0, 16'h0, 16'h1234, n);
    chk("R10", "push latency", n, 3);
    chk("R10", "busy at done", busy, 0);
    chk("R7", "hi byte at FFFF", peek(16'hFFFF), 8'h12);
    chk("R2", "lo byte at FFFE", peek(16'hFFFE), 8'h34);
    chk("R2", "sp after push", sp, 16'hFFFE);
    chk("R7", "no write at 0000", peek(16'h0000), 8'h00);
    @(negedge clk);
    chk("R10", "done single cycle", done, 0);
  endtask

  task automatic t_push_af();
    int n;
    issue(2'd0, 2'd3, 16'h0, 16'hA55A, n);
    chk("R4", "accumulator at higher addr", peek(16'hFFFD), 8'hA5);
    chk("R4", "flags at lower addr", peek(16'hFFFC), 8'h5A);
    chk("R2", "sp after second push", sp, 16'hFFFC);
    chk("R9", "res_pair untouched by push", res_pair, 16'h0000);
  endtask

  task automatic t_pop_de();
    int n;
    issue(2'd1, 2'd1, 16'h0, 16'h0, n);
    chk("R10", "pop latency", n, 4);
    chk("R3", "popped pair", res_pair, 16'hA55A);
    chk("R3", "res_sel", res_sel, 2'd1);
    chk("R3", "sp after pop", sp, 16'hFFFE);
  endtask

  task automatic t_xchg();
    int n;
    issue(2'd2, 2'd2, 16'h0, 16'hBEEF, n);
    chk("R10", "swap latency", n, 5);
    chk("R5", "old stack top", res_pair, 16'h1234);
    chk("R5", "res_sel", res_sel, 2'd2);
    chk("R5", "L to sp", peek(16'hFFFE), 8'hEF);
    chk("R5", "H to sp+1", peek(16'hFFFF), 8'hBE);
    chk("R5", "sp unchanged", sp, 16'hFFFE);
  endtask

  task automatic t_ldhl();
    int n;
    mem[32'h1000] = 8'h11;
    mem[32'h1001] = 8'h22;
    issue(2'd3, 2'd0, 16'h1000, 16'hFFFF, n);
    chk("R10", "load latency", n, 4);
    chk("R6", "loaded pair", res_pair, 16'h2211);
    chk("R6", "res_sel", res_sel, 2'd2);
    chk("R6", "sp unchanged", sp, 16'hFFFE);
    chk("R6", "mem lo intact", peek(16'h1000), 8'h11);
    chk("R6", "mem hi intact", peek(16'h1001), 8'h22);
  endtask

  task automatic t_ldhl_wrap();
    int n;
    mem[32'h0000] = 8'h77;
    issue(2'd3, 2'd0, 16'hFFFF, 16'h0, n);
    chk("R7", "load across wrap", res_pair, 16'h77BE);
  endtask

  task automatic t_busy_ignore();
    int dones = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_pair = 2'd2; cmd_data = 16'hCAFE;
    @(posedge clk);
    @(negedge clk);
    cmd_op = 2'd1; cmd_data = 16'h0BAD;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk("R8", "done count", dones, 1);
    chk("R8", "sp moved only by push", sp, 16'hFFFC);
    chk("R8", "pushed hi", peek(16'hFFFD), 8'hCA);
    chk("R8", "pushed lo", peek(16'hFFFC), 8'hFE);
    chk("R9", "res_pair held", res_pair, 16'h77BE);
  endtask

  task automatic t_pop_hl();
    int n;
    issue(2'd1, 2'd2, 16'h0, 16'h0, n);
    chk("R3", "pop HL", res_pair, 16'hCAFE);
    chk("R3", "res_sel HL", res_sel, 2'd2);
    chk("R3", "sp back", sp, 16'hFFFE);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_push_bc();
    t_push_af();
    t_pop_de();
    t_xchg();
    t_ldhl();
    t_ldhl_wrap();
    t_busy_ignore();
    t_pop_hl();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule